// File: doc/BRIEF.md
# Command Packet Register Decoder

This block takes 32-bit control words from a valid/ready input stream. Each word is one packet. The top nibble is an opcode, the next twelve bits are a register address and the low sixteen bits are a data value. The block holds each word in a capture register and checks it before it changes anything. A word that passes as a write updates one 16-bit register of a small bank. A word that passes as a read produces one response word on a valid/ready output stream. A word with an unknown opcode, or with an address outside the implemented window, is discarded. The only trace it leaves is a step of a saturating error counter.

The whole register bank is also driven out as one flat parallel vector, so that downstream configuration logic can use it directly. Each accepted write also raises a one-cycle strobe that carries the written address.

The control is a three-state machine:
- **IDLE**: input ready is high. A handshake captures the word and moves to CHECK.
- **CHECK**: the captured word is classified.
  - A valid write goes back to IDLE and commits the write on that edge.
  - A valid read loads the response and moves to RESPOND.
  - A rejected word goes back to IDLE and counts an error.
- **RESPOND**: the response is held until the consumer takes it, then the machine returns to IDLE.

Top module: `cmd_reg_decoder`

## Requirements
- R1: A word's fields are: opcode in bits [31:28], register address in bits [27:16], data in bits [15:0].
- R2: A word with opcode 0x1 and an implemented address (0x000 to 0x01F by default) updates that register. The new value is visible, and `wr_strobe` is high with `wr_addr` equal to the address, in the second cycle after the input handshake. The strobe lasts exactly one cycle.
- R3: In the cycle after the handshake, while the word is being checked, no register has changed and `wr_strobe` is low.
- R4: A word whose opcode is neither 0x1 nor 0x2 changes no register, produces no response and no strobe, and adds one to `err_count`.
- R5: A word with a valid opcode but an address outside the implemented window (0x020 to 0xFFF by default) is handled like R4.
- R6: `err_count` is 8 bits wide and stops at 255; it does not wrap.
- R7: A word with opcode 0x2 and an implemented address raises `rsp_valid` in the second cycle after the handshake.
  - The response word is {4'h2, address, register value}.
  - The response stays valid and stable until it is taken with `rsp_ready`.
- R8: `in_ready` is low from the cycle after a handshake until the packet is finished, including the whole time a response waits for `rsp_ready`.
- R9: A synchronous active-high `rst` clears every register, `err_count`, `rsp_valid` and `wr_strobe`, and sets `in_ready`.
- R10: Register i appears on `cfg_regs[16*i+15:16*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 32 | Input packet word |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Read response word |
| wr_strobe | output | 1 | One-cycle pulse on an accepted write |
| wr_addr | output | 12 | Address of the accepted write |
| cfg_regs | output | NUM_REGS*16 | Flat copy of the register bank |
| err_count | output | ERR_W | Saturating count of rejected words |

## Verification
The assertions assume two things about the consumer and the producer:
- The consumer may hold `rsp_ready` low for any number of cycles.
- The producer presents a word only while `in_ready` is high.

Under these assumptions a held response must stay stable, and writes are the only source of register change.

The bench keeps within these limits. It drives `in_valid` only in a cycle where it has seen `in_ready` high, and it drops `in_valid` right after the handshake. It holds `rsp_ready` low for a random zero to three cycles before taking each response.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;
    localparam int PKT_W  = 32;
    localparam int OP_W   = 4;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;

    localparam logic [OP_W-1:0] OP_WRITE = 4'h1;
    localparam logic [OP_W-1:0] OP_READ  = 4'h2;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_CHECK   = 2'd1,
        S_RESPOND = 2'd2
    } dec_state_t;
endpackage

// File: rtl/pkt_checker.sv
module pkt_checker
    import cmdreg_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter int BASE_ADDR = 0,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [PKT_W-1:0]  word,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              is_write,
    output logic              is_read,
    output logic              addr_hit,
    output logic [IDX_W-1:0]  reg_idx
);
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] offset;

    // R1: field positions of the packet word
    always_comb begin
        op       = word[PKT_W-1 -: OP_W];
        addr     = word[DATA_W +: ADDR_W];
        data     = word[DATA_W-1:0];
        is_write = (op == OP_WRITE);
        is_read  = (op == OP_READ);
        offset   = addr - ADDR_W'(BASE_ADDR);
        addr_hit = (addr >= ADDR_W'(BASE_ADDR)) && (offset < ADDR_W'(NUM_REGS));
        reg_idx  = offset[IDX_W-1:0];
    end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import cmdreg_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int FLAT_W  = NUM_REGS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata,
    output logic [FLAT_W-1:0] flat
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (we && widx == IDX_W'(g))
                q <= wdata;
        end
        assign flat[g*DATA_W +: DATA_W] = q;  // R10 packing
    end

    assign rdata = flat[ridx*DATA_W +: DATA_W];

    // R4 R5: registers move only on a write enable
    a_r4_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(flat));
endmodule

// File: rtl/err_counter.sv
module err_counter #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [ERR_W-1:0] count
);
    localparam logic [ERR_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (bump && count != TOP)
            count <= count + 1'b1;
    end

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        count == TOP |=> count == TOP);
    a_r4_single_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1));
endmodule

// File: rtl/cmd_reg_decoder.sv
module cmd_reg_decoder
    import cmdreg_pkg::*;
#(
    parameter int NUM_REGS  = 32,
    parameter int BASE_ADDR = 0,
    parameter int ERR_W     = 8,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int FLAT_W   = NUM_REGS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PKT_W-1:0]  in_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PKT_W-1:0]  rsp_data,
    output logic              wr_strobe,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [FLAT_W-1:0] cfg_regs,
    output logic [ERR_W-1:0]  err_count
);
    dec_state_t        state_q, state_d;
    logic [PKT_W-1:0]  word_q;
    logic [ADDR_W-1:0] pk_addr;
    logic [DATA_W-1:0] pk_data;
    logic              pk_wr, pk_rd, pk_hit;
    logic [IDX_W-1:0]  pk_idx;
    logic [DATA_W-1:0] rd_value;
    logic              take_wr, take_rd, drop_pkt;

    pkt_checker #(.NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)) u_chk (
        .word(word_q), .addr(pk_addr), .data(pk_data),
        .is_write(pk_wr), .is_read(pk_rd), .addr_hit(pk_hit), .reg_idx(pk_idx)
    );

    always_comb begin
        take_wr  = (state_q == S_CHECK) && pk_wr && pk_hit;
        take_rd  = (state_q == S_CHECK) && pk_rd && pk_hit;
        drop_pkt = (state_q == S_CHECK) && !(pk_hit && (pk_wr || pk_rd));
        in_ready = (state_q == S_IDLE);
    end

    reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst(rst), .we(take_wr), .widx(pk_idx), .wdata(pk_data),
        .ridx(pk_idx), .rdata(rd_value), .flat(cfg_regs)
    );

    err_counter #(.ERR_W(ERR_W)) u_err (
        .clk(clk), .rst(rst), .bump(drop_pkt), .count(err_count)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (in_valid)  state_d = S_CHECK;
            S_CHECK:   state_d = take_rd ? S_RESPOND : S_IDLE;
            S_RESPOND: if (rsp_ready) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register and packet capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && in_valid)
                word_q <= in_data;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_strobe <= 1'b0;
            wr_addr   <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            wr_strobe <= take_wr;
            if (take_wr)
                wr_addr <= pk_addr;
            if (take_rd) begin
                rsp_valid <= 1'b1;
                rsp_data  <= {OP_READ, pk_addr, rd_value};
            end else if (rsp_valid && rsp_ready) begin
                rsp_valid <= 1'b0;
            end
        end
    end

    a_r8_block_while_pending: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !in_ready);
    a_r7_hold_response: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
    a_r2_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> !wr_strobe);
    a_r3_no_early_strobe: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_CHECK) |-> !wr_strobe);
    a_r5_drop_is_silent: assert property (@(posedge clk) disable iff (rst)
        drop_pkt |=> (!wr_strobe && !rsp_valid));
endmodule

// File: tb/tb_cmd_reg_decoder.sv
`timescale 1ns/1ps
module tb_cmd_reg_decoder;
    localparam int NREG = 32;

    logic        clk = 1'b0;
    logic        rst, in_valid, in_ready, rsp_valid, rsp_ready, wr_strobe;
    logic [31:0] in_data, rsp_data;
    logic [11:0] wr_addr;
    logic [NREG*16-1:0] cfg_regs;
    logic [7:0]  err_count;

    cmd_reg_decoder dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .cfg_regs(cfg_regs), .err_count(err_count)
    );

    always #4 clk = ~clk;

    int nchk = 0, nerr = 0;
    bit done = 0;
    logic [15:0] mdl [NREG];
    int merr = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit f_mapped(input logic [11:0] a);
        return a < 12'(NREG);
    endfunction
    function automatic logic [31:0] f_rsp(input logic [11:0] a, input logic [15:0] d);
        return {4'h2, a, d};
    endfunction

    task automatic chk_bank(input string req);
        for (int i = 0; i < NREG; i++)
            chk(req, 32'(cfg_regs[i*16 +: 16]), 32'(mdl[i]));
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; in_data = '0; rsp_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NREG; i++) mdl[i] = '0;
        merr = 0;
        @(negedge clk);
    endtask

    task automatic send(input logic [31:0] w, input int hold);
        logic [3:0]  op;
        logic [11:0] a;
        logic [15:0] d;
        op = w[31:28]; a = w[27:16]; d = w[15:0];
        chk("R8 ready in idle", 32'(in_ready), 32'd1);
        in_valid = 1'b1; in_data = w;
        @(negedge clk);
        in_valid = 1'b0; in_data = $urandom;
        chk("R8 ready low while checking", 32'(in_ready), 32'd0);
        chk("R3 no strobe while checking", 32'(wr_strobe), 32'd0);
        if (f_mapped(a))
            chk("R3 register unchanged while checking", 32'(cfg_regs[a*16 +: 16]), 32'(mdl[a]));
        @(negedge clk);
        if (op == 4'h1 && f_mapped(a)) begin
            mdl[a] = d;
            chk("R2 strobe", 32'(wr_strobe), 32'd1);
            chk("R2 strobe address", 32'(wr_addr), 32'(a));
            chk("R2 register updated", 32'(cfg_regs[a*16 +: 16]), 32'(d));
            chk("R2 no response on write", 32'(rsp_valid), 32'd0);
            @(negedge clk);
            chk("R2 strobe one cycle", 32'(wr_strobe), 32'd0);
        end else if (op == 4'h2 && f_mapped(a)) begin
            chk("R7 response valid", 32'(rsp_valid), 32'd1);
            chk("R7 R1 response word", rsp_data, f_rsp(a, mdl[a]));
            for (int k = 0; k < hold; k++) begin
                @(negedge clk);
                chk("R7 response held", rsp_data, f_rsp(a, mdl[a]));
                chk("R8 ready low while response waits", 32'(in_ready), 32'd0);
            end
            rsp_ready = 1'b1;
            @(negedge clk);
            rsp_ready = 1'b0;
            chk("R7 response consumed", 32'(rsp_valid), 32'd0);
        end else begin
            if (merr < 255) merr++;
            chk(op == 4'h1 || op == 4'h2 ? "R5 no strobe on unmapped" : "R4 no strobe on bad opcode",
                32'(wr_strobe), 32'd0);
            chk(op == 4'h1 || op == 4'h2 ? "R5 no response on unmapped" : "R4 no response on bad opcode",
                32'(rsp_valid), 32'd0);
        end
        chk("R4 R5 R6 error count", 32'(err_count), 32'(merr));
    endtask

    function automatic logic [31:0] rand_word();
        int r;
        logic [3:0]  op;
        logic [11:0] a;
        r = $urandom_range(0, 9);
        op = (r < 4) ? 4'h1 : (r < 8) ? 4'h2 : 4'($urandom_range(0, 15));
        a = ($urandom_range(0, 99) < 85) ? 12'($urandom_range(0, NREG-1))
                                          : 12'($urandom_range(0, 4095));
        return {op, a, 16'($urandom)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R9 reset state
        chk("R9 err cleared", 32'(err_count), 32'd0);
        chk("R9 no response", 32'(rsp_valid), 32'd0);
        chk("R9 no strobe", 32'(wr_strobe), 32'd0);
        chk("R9 ready", 32'(in_ready), 32'd1);
        chk_bank("R9 R10 bank cleared");

        // directed corners
        send({4'h1, 12'h000, 16'hA5C3}, 0);
        send({4'h1, 12'h01F, 16'h1234}, 0);
        send({4'h2, 12'h01F, 16'h0000}, 2);
        send({4'h2, 12'h000, 16'hFFFF}, 0);
        send({4'h1, 12'h020, 16'hDEAD}, 0);   // R5 first unmapped
        send({4'h2, 12'hFFF, 16'h0000}, 0);   // R5 top of space
        send({4'h0, 12'h001, 16'hBEEF}, 0);   // R4
        send({4'h3, 12'h002, 16'hBEEF}, 0);   // R4
        send({4'hF, 12'h003, 16'hBEEF}, 0);   // R4
        chk_bank("R10 bank after directed");

        // constrained random mix
        for (int n = 0; n < 400; n++)
            send(rand_word(), $urandom_range(0, 3));
        chk_bank("R10 bank after random");

        // R6 saturation
        for (int n = 0; n < 260; n++)
            send({4'h9, 12'(n), 16'(n)}, 0);
        chk("R6 saturated at 255", 32'(err_count), 32'd255);
        chk_bank("R4 bank untouched by bad words");

        // R9 reset mid-run
        do_reset();
        chk("R9 err cleared after run", 32'(err_count), 32'd0);
        chk_bank("R9 bank cleared after run");

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule